// File: doc/BRIEF.md
# Floating-Point Adder/Subtracter with Optional Subnormal Handling

This block takes two IEEE binary32 operands, or any narrower or wider format chosen by its exponent and fraction width parameters, and returns their correctly rounded sum or difference one clock later. An operation select negates the second operand, so a single datapath serves both addition and subtraction. Inside, the operand of greater magnitude always feeds the left path. When the exponents are equal, the significands decide which operand is larger, so the integer subtraction never produces a negative value. The smaller operand is shifted right to line up with the larger one, and every bit shifted out is collapsed into a sticky bit. After the add or subtract, a leading-zero count drives a left shift that normalizes the result, and rounding is round-to-nearest with ties to even.

A configuration input selects how zero-exponent encodings are treated. With it set, such an operand is a subnormal: its hidden significand bit is 0 and its exponent counts as 1. Results too small for the normal range are then returned as subnormals. With it clear, zero-exponent operands count as zeros of their own sign, and results below the smallest normal magnitude are flushed to zero. NaN inputs, infinities and overflow are resolved in parallel with the datapath.

Top module: `fp_addsub`

## Requirements
- R1: `result` is a register. It holds all zeros while `rst` is high, and it presents the value computed from the inputs sampled at one rising edge after that edge.
- R2: For finite operands, `result` equals the exact value of `op_a + op_b` (or `op_a - op_b` when `op_sub` is 1), rounded to nearest with ties to the even fraction.
- R3: A nonzero result takes the sign of the operand with the larger magnitude, after `op_sub` has been applied to `op_b`. Equal magnitudes under effective subtraction give +0 (all bits zero).
- R4: An exact zero result is +0, except when both operands are zeros carrying a negative sign after `op_sub` is applied; that case gives -0 (sign bit 1, other bits 0).
- R5: When `denorm_en` is 1, a zero exponent field means hidden bit 0 and exponent 1. A result below the smallest normal magnitude is output with exponent field 0 and the exact fraction.
- R6: When `denorm_en` is 0, a zero-exponent operand counts as a zero of its own sign. A result below the smallest normal magnitude becomes a zero that keeps the result's sign. `result` never has a zero exponent field together with a nonzero fraction.
- R7: If either operand is a NaN (exponent all ones, fraction nonzero), `result` is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0.
- R8: Two infinities of opposite effective sign give the canonical quiet NaN. Otherwise an infinite operand gives an infinity with that operand's effective sign.
- R9: A finite result whose rounded exponent reaches the all-ones field becomes an infinity of the result's sign; a finite computation never yields a NaN.
- R10: When the exponent difference is larger than the aligned significand width, the smaller nonzero operand still takes part in rounding through the sticky bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 1+EXP_W+FRAC_W | First operand: sign, exponent field, fraction |
| op_b | input | 1+EXP_W+FRAC_W | Second operand, same layout |
| op_sub | input | 1 | 1 selects op_a - op_b, 0 selects op_a + op_b |
| denorm_en | input | 1 | 1 handles zero-exponent values as subnormals, 0 flushes them to zero |
| result | output | 1+EXP_W+FRAC_W | Registered rounded result |

## Verification
Some properties are checked on every cycle by the assertions:
- the reset value;
- that NaN inputs and opposing infinities give the canonical quiet NaN one cycle later;
- that `x - x` gives +0 for finite `x`;
- that flush mode never outputs a subnormal encoding;
- that a NaN never comes out of finite or same-signed operands.

The exact rounded value depends on the whole alignment, cancellation and rounding chain, so only the bench's scenarios can show it. The same holds for the sign of cancelled and flushed results, the treatment of subnormal operands, and the sticky effect of operands shifted fully out of range. For these, the bench sweeps every operand pair, both operations and both modes of a six-bit format against an exact integer model, and adds directed binary32 cases for tie rounding, overflow and the subnormal boundary.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Number of extra bits kept below the significand LSB: guard, round, sticky.
    localparam int GRS_W = 3;

    typedef enum logic [1:0] {
        CLS_FIN = 2'd0,
        CLS_INF = 2'd1,
        CLS_NAN = 2'd2
    } fpa_cls_e;

    // Leading zeros in the lowest w bits of v.
    function automatic int unsigned count_lead_zeros(input logic [63:0] v, input int unsigned w);
        int unsigned n;
        logic        seen;
        n    = 0;
        seen = 1'b0;
        for (int i = 63; i >= 0; i--) begin
            if (i < int'(w) && !seen) begin
                if (v[i]) seen = 1'b1;
                else      n++;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpa_unpack_swap.sv
module fpa_unpack_swap
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SIG_W = FRAC_W + 1
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             op_sub,
    input  logic             denorm_en,
    output logic             sign_a,
    output logic             sign_b,
    output fpa_cls_e         cls_a,
    output fpa_cls_e         cls_b,
    output logic             sign_l,
    output logic             sign_r,
    output logic [EXP_W-1:0] exp_l,
    output logic [EXP_W-1:0] exp_diff,
    output logic [SIG_W-1:0] sig_l,
    output logic [SIG_W-1:0] sig_r
);

    typedef struct packed {
        logic             sign;
        fpa_cls_e         cls;
        logic [EXP_W-1:0] eexp;
        logic [SIG_W-1:0] sig;
    } dec_t;

    for (genvar i = 0; i < 2; i++) begin : g_dec
        logic [W-1:0]      word;
        logic [EXP_W-1:0]  ef;
        logic [FRAC_W-1:0] ff;
        dec_t              d;

        assign word = (i == 0) ? op_a : op_b;
        assign ef   = word[W-2 -: EXP_W];
        assign ff   = word[FRAC_W-1:0];

        always_comb begin
            d.sign = word[W-1] ^ ((i == 1) & op_sub);
            if (&ef) d.cls = (|ff) ? CLS_NAN : CLS_INF;
            else     d.cls = CLS_FIN;
            if (ef == '0) begin
                d.eexp = EXP_W'(1);
                d.sig  = denorm_en ? {1'b0, ff} : '0;
            end else begin
                d.eexp = ef;
                d.sig  = {1'b1, ff};
            end
        end
    end

    dec_t da, db, left, right;
    logic a_first;

    assign da = g_dec[0].d;
    assign db = g_dec[1].d;

    // Exponent first, significand as tiebreak: left is never smaller than right.
    assign a_first = {da.eexp, da.sig} >= {db.eexp, db.sig};

    always_comb begin
        left     = a_first ? da : db;
        right    = a_first ? db : da;
        sign_a   = da.sign;
        sign_b   = db.sign;
        cls_a    = da.cls;
        cls_b    = db.cls;
        sign_l   = left.sign;
        sign_r   = right.sign;
        exp_l    = left.eexp;
        exp_diff = left.eexp - right.eexp;
        sig_l    = left.sig;
        sig_r    = right.sig;
    end

endmodule

// File: rtl/fpa_align.sv
module fpa_align
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W = FRAC_W + 1,
    localparam int EXT_W = SIG_W + GRS_W
) (
    input  logic [SIG_W-1:0] sig_r,
    input  logic [EXP_W-1:0] exp_diff,
    output logic [EXT_W-1:0] aligned
);

    logic [EXT_W-1:0] ext, shifted, lost_mask;
    logic             sticky;

    always_comb begin
        ext = {sig_r, GRS_W'(0)};
        if (32'(exp_diff) >= EXT_W) begin
            shifted   = '0;
            lost_mask = '1;
        end else begin
            shifted   = ext >> exp_diff;
            lost_mask = ~({EXT_W{1'b1}} << exp_diff);
        end
        sticky  = |(ext & lost_mask);
        aligned = shifted | {{(EXT_W-1){1'b0}}, sticky};
    end

endmodule

// File: rtl/fpa_norm_round.sv
module fpa_norm_round
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int SUM_W = FRAC_W + 1 + GRS_W + 1
) (
    input  logic [SUM_W-1:0] sum,
    input  logic [EXP_W-1:0] exp_l,
    input  logic             sign_l,
    input  logic             eff_sub,
    input  logic             denorm_en,
    output logic [W-1:0]     word
);

    localparam int CNT_W = $clog2(SUM_W + 1);
    localparam int NE_W  = ((EXP_W > CNT_W) ? EXP_W : CNT_W) + 2;
    localparam logic [NE_W-1:0] EMAX = NE_W'((1 << EXP_W) - 1);

    logic [CNT_W-1:0]  lz;
    logic [NE_W-1:0]   nexp, efin, shamt;
    logic              tiny, g_bit, r_bit, s_bit, inc;
    logic [SUM_W-1:0]  norm;
    logic [FRAC_W+1:0] mant;

    always_comb begin
        lz    = CNT_W'(count_lead_zeros(64'(sum), SUM_W));
        // First exponent update: alignment exponent plus carry, minus cancellation.
        nexp  = NE_W'(exp_l) + NE_W'(1) - NE_W'(lz);
        tiny  = nexp[NE_W-1] | (nexp == '0);
        shamt = tiny ? NE_W'(exp_l) : NE_W'(lz);
        norm  = sum << shamt;
        g_bit = norm[GRS_W];
        r_bit = norm[GRS_W-1];
        s_bit = |norm[GRS_W-2:0];
        inc   = g_bit & (r_bit | s_bit | norm[GRS_W+1]);
        mant  = {1'b0, norm[SUM_W-1:GRS_W+1]} + (FRAC_W+2)'(inc);
        // Second exponent update: rounding carry.
        efin  = mant[FRAC_W+1] ? nexp + NE_W'(1) : nexp;

        if (sum == '0) begin
            word = {(~eff_sub) & sign_l, {(W-1){1'b0}}};
        end else if (tiny) begin
            if (denorm_en) word = {sign_l, EXP_W'(mant[FRAC_W]), mant[FRAC_W-1:0]};
            else           word = {sign_l, {(W-1){1'b0}}};
        end else if (efin >= EMAX) begin
            word = {sign_l, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            word = {sign_l, efin[EXP_W-1:0], mant[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
    import fpa_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_sub,
    input  logic         denorm_en,
    output logic [W-1:0] result
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + GRS_W;
    localparam int SUM_W = EXT_W + 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic             sign_a, sign_b, sign_l, sign_r, eff_sub;
    fpa_cls_e         cls_a, cls_b;
    logic [EXP_W-1:0] exp_l, exp_diff;
    logic [SIG_W-1:0] sig_l, sig_r;
    logic [EXT_W-1:0] aligned;
    logic [SUM_W-1:0] sum;
    logic [W-1:0]     fin_word, nxt;

    fpa_unpack_swap #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_swap (
        .op_a(op_a), .op_b(op_b), .op_sub(op_sub), .denorm_en(denorm_en),
        .sign_a(sign_a), .sign_b(sign_b), .cls_a(cls_a), .cls_b(cls_b),
        .sign_l(sign_l), .sign_r(sign_r), .exp_l(exp_l), .exp_diff(exp_diff),
        .sig_l(sig_l), .sig_r(sig_r)
    );

    fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .sig_r(sig_r), .exp_diff(exp_diff), .aligned(aligned)
    );

    assign eff_sub = sign_l ^ sign_r;

    // Left is never smaller than right, so the difference stays non-negative.
    always_comb begin
        if (eff_sub) sum = {1'b0, sig_l, GRS_W'(0)} - {1'b0, aligned};
        else         sum = {1'b0, sig_l, GRS_W'(0)} + {1'b0, aligned};
    end

    fpa_norm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .sum(sum), .exp_l(exp_l), .sign_l(sign_l), .eff_sub(eff_sub),
        .denorm_en(denorm_en), .word(fin_word)
    );

    always_comb begin
        if (cls_a == CLS_NAN || cls_b == CLS_NAN)
            nxt = QNAN;
        else if (cls_a == CLS_INF && cls_b == CLS_INF)
            nxt = (sign_a != sign_b) ? QNAN : {sign_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (cls_a == CLS_INF)
            nxt = {sign_a, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (cls_b == CLS_INF)
            nxt = {sign_b, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            nxt = fin_word;
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= nxt;
    end

endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         op_sub,
    input logic         denorm_en,
    input logic [W-1:0] result
);

    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic nan_a, nan_b, inf_a, inf_b, inf_clash, res_emax, res_ezero, res_fnz;

    assign nan_a     = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
    assign nan_b     = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
    assign inf_a     = (&op_a[W-2 -: EXP_W]) && !(|op_a[FRAC_W-1:0]);
    assign inf_b     = (&op_b[W-2 -: EXP_W]) && !(|op_b[FRAC_W-1:0]);
    assign inf_clash = inf_a && inf_b && (op_a[W-1] != (op_b[W-1] ^ op_sub));
    assign res_emax  = &result[W-2 -: EXP_W];
    assign res_ezero = result[W-2 -: EXP_W] == '0;
    assign res_fnz   = |result[FRAC_W-1:0];

    // R1
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (result == '0));

    // R7
    a_r7_nan_quiet: assert property (@(posedge clk) disable iff (rst)
        (nan_a || nan_b) |=> (result == QNAN));

    // R8
    a_r8_inf_clash: assert property (@(posedge clk) disable iff (rst)
        inf_clash |=> (result == QNAN));

    // R3
    a_r3_self_cancel: assert property (@(posedge clk) disable iff (rst)
        (op_sub && op_a == op_b && !nan_a && !inf_a) |=> (result == '0));

    // R6
    a_r6_flush_clean: assert property (@(posedge clk) disable iff (rst)
        !denorm_en |=> !(res_ezero && res_fnz));

    // R9
    a_r9_no_false_nan: assert property (@(posedge clk) disable iff (rst)
        (!nan_a && !nan_b && !inf_clash) |=> !(res_emax && res_fnz));

endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .denorm_en(denorm_en), .result(result)
);

// File: tb/tb_fp_addsub.sv
module tb_fp_addsub;

    localparam int CLK_PERIOD = 10;
    localparam int SE   = 3;
    localparam int SF   = 2;
    localparam int SW   = 1 + SE + SF;
    localparam int MAXE = (1 << SE) - 1;
    localparam logic [SW-1:0] QNAN_S = {1'b0, {SE{1'b1}}, 1'b1, {(SF-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] s_a = '0, s_b = '0;
    logic          s_sub = 1'b0, s_dn = 1'b0;
    logic [SW-1:0] s_res;
    logic [31:0]   w_a = '0, w_b = '0;
    logic          w_sub = 1'b0, w_dn = 1'b0;
    logic [31:0]   w_res;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_addsub #(.EXP_W(SE), .FRAC_W(SF)) dut (
        .clk(clk), .rst(rst), .op_a(s_a), .op_b(s_b), .op_sub(s_sub),
        .denorm_en(s_dn), .result(s_res)
    );

    fp_addsub dut_sp (
        .clk(clk), .rst(rst), .op_a(w_a), .op_b(w_b), .op_sub(w_sub),
        .denorm_en(w_dn), .result(w_res)
    );

    function automatic int mag_of(input logic [SE-1:0] e, input logic [SF-1:0] f, input logic dn);
        if (e == '0) return dn ? int'(f) : 0;
        return ((1 << SF) | int'(f)) << (int'(e) - 1);
    endfunction

    // Exact integer model in units of the smallest subnormal step.
    function automatic logic [SW-1:0] ref_add(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                              input logic sub, input logic dn, output string tag);
        logic          sa, sb, s;
        logic [SE-1:0] ea, eb;
        logic [SF-1:0] fa, fb;
        int ma, mb, sum, m, p, sh, keep, rem, half, field, eea, eeb;
        sa = a[SW-1]; ea = a[SW-2 -: SE]; fa = a[SF-1:0];
        sb = b[SW-1] ^ sub; eb = b[SW-2 -: SE]; fb = b[SF-1:0];
        tag = "R2";
        if ((ea == MAXE && fa != 0) || (eb == MAXE && fb != 0)) begin tag = "R7"; return QNAN_S; end
        if (ea == MAXE && eb == MAXE) begin
            tag = "R8";
            return (sa != sb) ? QNAN_S : {sa, {SE{1'b1}}, {SF{1'b0}}};
        end
        if (ea == MAXE) begin tag = "R8"; return {sa, {SE{1'b1}}, {SF{1'b0}}}; end
        if (eb == MAXE) begin tag = "R8"; return {sb, {SE{1'b1}}, {SF{1'b0}}}; end
        ma = mag_of(ea, fa, dn);
        mb = mag_of(eb, fb, dn);
        eea = (ea == 0) ? 1 : int'(ea);
        eeb = (eb == 0) ? 1 : int'(eb);
        if (ma != 0 && mb != 0 && (eea - eeb > SF + 4 || eeb - eea > SF + 4)) tag = "R10";
        if (sa != sb && mb > ma) tag = "R3";
        if (!dn && ((ea == 0 && fa != 0) || (eb == 0 && fb != 0))) tag = "R6";
        sum = (sa ? -ma : ma) + (sb ? -mb : mb);
        if (sum == 0) begin
            tag = "R4";
            return {(ma == 0 && mb == 0 && sa && sb), {(SW-1){1'b0}}};
        end
        s = sum < 0;
        m = s ? -sum : sum;
        p = 0;
        for (int i = 0; i < 16; i++) if (((m >> i) & 1) == 1) p = i;
        if (p < SF) begin
            if (dn) begin tag = "R5"; return {s, {SE{1'b0}}, SF'(m)}; end
            tag = "R6";
            return {s, {(SW-1){1'b0}}};
        end
        sh = p - SF;
        keep = m >> sh;
        if (sh > 0) begin
            rem  = m & ((1 << sh) - 1);
            half = 1 << (sh - 1);
            if (rem > half || (rem == half && (keep % 2) == 1)) keep++;
        end
        if (keep == (2 << SF)) begin keep = keep >> 1; sh++; end
        field = sh + 1;
        if (field >= MAXE) begin tag = "R9"; return {s, {SE{1'b1}}, {SF{1'b0}}}; end
        return {s, SE'(field), SF'(keep)};
    endfunction

    task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                             input logic sub, input logic dn);
        string         tag;
        logic [SW-1:0] exp_v;
        exp_v = ref_add(a, b, sub, dn, tag);
        s_a = a; s_b = b; s_sub = sub; s_dn = dn;
        @(negedge clk);
        checks++;
        if (s_res !== exp_v) begin
            fails++;
            $display("FAIL %s: a=%h b=%h sub=%0d dn=%0d got %h expected %h",
                     tag, a, b, sub, dn, s_res, exp_v);
        end
    endtask

    task automatic run_sp(input logic [31:0] a, input logic [31:0] b, input logic sub,
                          input logic dn, input logic [31:0] exp_v, input string tag);
        w_a = a; w_b = b; w_sub = sub; w_dn = dn;
        @(negedge clk);
        checks++;
        if (w_res !== exp_v) begin
            fails++;
            $display("FAIL %s: a=%h b=%h sub=%0d dn=%0d got %h expected %h",
                     tag, a, b, sub, dn, w_res, exp_v);
        end
    endtask

    task automatic check_reset(input string tag);
        checks++;
        if (s_res !== '0 || w_res !== '0) begin
            fails++;
            $display("FAIL %s: reset state got %h/%h expected 0/0", tag, s_res, w_res);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset("R1");
        rst = 1'b0;

        // Exhaustive sweep of the small format: R2..R10.
        for (int dn = 0; dn < 2; dn++)
            for (int sub = 0; sub < 2; sub++)
                for (int a = 0; a < (1 << SW); a++)
                    for (int b = 0; b < (1 << SW); b++)
                        run_small(SW'(a), SW'(b), sub[0], dn[0]);

        // Directed binary32 cases.
        run_sp(32'h3f800000, 32'h40000000, 1'b0, 1'b1, 32'h40400000, "R2");
        run_sp(32'h3f800000, 32'h33800000, 1'b0, 1'b1, 32'h3f800000, "R2");
        run_sp(32'h3f800000, 32'h33c00000, 1'b0, 1'b1, 32'h3f800001, "R2");
        run_sp(32'h3f800000, 32'h00000001, 1'b0, 1'b1, 32'h3f800000, "R10");
        run_sp(32'hbf800000, 32'h3f000000, 1'b0, 1'b1, 32'hbf000000, "R3");
        run_sp(32'h3f800000, 32'h3f800000, 1'b1, 1'b1, 32'h00000000, "R3");
        run_sp(32'h80000000, 32'h80000000, 1'b0, 1'b1, 32'h80000000, "R4");
        run_sp(32'h00000001, 32'h00000001, 1'b0, 1'b1, 32'h00000002, "R5");
        run_sp(32'h00800000, 32'h00000001, 1'b1, 1'b1, 32'h007fffff, "R5");
        run_sp(32'h00000001, 32'h00000001, 1'b0, 1'b0, 32'h00000000, "R6");
        run_sp(32'h7fc00001, 32'h3f800000, 1'b0, 1'b1, 32'h7fc00000, "R7");
        run_sp(32'h7f800000, 32'h7f800000, 1'b1, 1'b1, 32'h7fc00000, "R8");
        run_sp(32'hff800000, 32'h3f800000, 1'b0, 1'b0, 32'hff800000, "R8");
        run_sp(32'h7f7fffff, 32'h7f7fffff, 1'b0, 1'b1, 32'h7f800000, "R9");

        // Reset mid-run with live operands.
        s_a = SW'(6'h0d); s_b = SW'(6'h0e); w_a = 32'h3f800000; w_b = 32'h3f800000;
        rst = 1'b1;
        @(negedge clk);
        check_reset("R1");
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule